// File: doc/BRIEF.md
# Edge-Captured Interrupt Status Unit

This block gathers six asynchronous event lines into one interrupt request for a host. Each line passes through a two-stage synchroniser and a rising-edge detector. An edge on a line whose enable bit is set latches that line's status bit to one. The bit then stays set until the host clears the same enable bit. No write-to-clear register exists. Writing to the status address does nothing.

The interrupt request only reacts to the status word as a whole. A one-cycle pulse fires when the word changes from all zero to non-zero. A level flag is high for as long as any status bit is set. Bits that latch while the word is already non-zero produce no new pulse. To get the next interrupt, the host must disable, and so clear, every pending source. It then re-enables the sources it wants.

The host side is a plain register port: a write strobe, a one-bit address, write data and combinational read data. There is no streaming data path, so no valid/ready handshake is used. Reads never change state.

Top module: `eirq_unit`

## Requirements
- R1: After reset the enable register and the status register read as zero, and irq_pulse and irq_level are low.
- R2: A write with reg_addr=0 loads the enable register (bit i enables source i), and with reg_addr=0 reg_rdata returns it. With reg_addr=1, reg_rdata returns the status register (bit i for source i). Reading has no side effect.
- R3: A rising edge on an enabled src_i bit sets the matching status bit. The bit is visible three clock edges after the input rises: two synchroniser edges plus one latch edge.
- R4: Edges on a source whose enable bit is 0 leave its status bit at 0.
- R5: Falling edges and inputs held high set no status bit.
- R6: Clearing an enable bit clears its status bit on the next clock edge. The bit stays clear while the enable bit is 0.
- R7: Setting an enable bit while its source is already high does not set the status bit, because no edge occurs.
- R8: When the status word changes from zero to non-zero, irq_pulse is high for exactly one cycle. irq_level is high whenever the status word is non-zero.
- R9: Further status bits that latch while the word is non-zero produce no new irq_pulse.
- R10: Once the status word has returned to zero, a new enabled edge produces a new irq_pulse.
- R11: A write with reg_addr=1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Asynchronous event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = status register |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for reg_addr |
| irq_pulse | output | 1 | One-cycle interrupt request on an empty-to-pending change |
| irq_level | output | 1 | High while any status bit is set |

## Verification
The hardest case to reach from the ports is a source that is already high at the moment its enable bit is set. A clear-then-reenable sequence can easily turn that into a false capture.

The stimulus therefore:
- disables a source that is being driven high;
- re-enables it with the line still high, and expects no capture;
- raises a different line afterwards, to show that a fresh interrupt is armed.

A directed sequence also counts clock edges from an input change to the status change. This pins down the three-edge latency.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/eirq_sync_edge.sv
module eirq_sync_edge #(
  parameter int N_SRC  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] async_i,
  output logic [N_SRC-1:0] level_o,
  output logic [N_SRC-1:0] rise_o
);
  localparam int TOP = STAGES - 1;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[i]};
        last_q  <= chain_q[TOP];
      end
    end

    assign level_o[i] = chain_q[TOP];
    assign rise_o[i]  = chain_q[TOP] & ~last_q;
  end

  // A rise is reported for one cycle only (R3)
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eirq_status.sv
module eirq_status #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] enable_i,
  input  logic [N_SRC-1:0] rise_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] status_d;

  always_comb begin
    status_d = (status_q | (rise_i & enable_i)) & enable_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // Enabled rise is captured on the next edge
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_i & enable_i) != '0) |=>
      ((status_q & $past(rise_i & enable_i)) == $past(rise_i & enable_i)));

  // Any bit disabled in the previous cycle is clear now
  assert_disabled_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(enable_i)) == '0));

  // An enabled set bit never drops while its enable stays set
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enable_i & $past(enable_i) & $past(status_q) & ~status_q) == '0));
endmodule

// File: rtl/eirq_req_gen.sv
module eirq_req_gen #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status_i,
  output logic             pulse_o,
  output logic             level_o
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= |status_i;
  end

  assign level_o = |status_i;
  assign pulse_o = level_o & ~busy_q;

  assert_pulse_after_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> ($past(status_i) == '0));

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  assert_no_repulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i != '0) |=> !pulse_o);
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit
  import eirq_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             irq_pulse,
  output logic             irq_level
);
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] sync_lvl;
  logic [N_SRC-1:0] sync_rise;
  logic [N_SRC-1:0] status;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          enable_q <= '0;
    else if (reg_wr && sel == SEL_ENABLE) enable_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = (sel == SEL_STATUS) ? status : enable_q;
  end

  eirq_sync_edge #(.N_SRC(N_SRC), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .level_o (sync_lvl),
    .rise_o  (sync_rise)
  );

  eirq_status #(.N_SRC(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_q),
    .rise_i   (sync_rise),
    .status_o (status)
  );

  eirq_req_gen #(.N_SRC(N_SRC)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .pulse_o  (irq_pulse),
    .level_o  (irq_level)
  );

  // Status write leaves the enable register untouched
  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_STATUS) |=> $stable(enable_q));

  // A line that was high when enabled cannot be captured without a new rise
  assert_no_capture_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise == '0 && status == '0) |=> (status == '0));

  // Level flag agrees with status
  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == (status != '0));

  // Unused synchronised level kept visible to checks
  assert_rise_implies_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_rise & ~sync_lvl) == '0));
endmodule

// File: tb/eirq_unit_tb.sv
module eirq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_i = '0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic       irq_pulse;
  logic       irq_level;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eirq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_level(irq_level)
  );

  always @(negedge clk) if (irq_pulse) pulses++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [5:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // {enable, src, expected status, expected pulses}
  localparam logic [19:0] VEC [12] = '{
    {6'h3F, 6'h00, 6'h00, 2'd0},  // R1 baseline
    {6'h3F, 6'h05, 6'h05, 2'd1},  // R3 R8
    {6'h3F, 6'h0F, 6'h0F, 2'd0},  // R9
    {6'h3F, 6'h00, 6'h0F, 2'd0},  // R5 falling
    {6'h3C, 6'h00, 6'h0C, 2'd0},  // R6
    {6'h3C, 6'h03, 6'h0C, 2'd0},  // R4
    {6'h00, 6'h03, 6'h00, 2'd0},  // R6
    {6'h3F, 6'h03, 6'h00, 2'd0},  // R7
    {6'h3F, 6'h23, 6'h20, 2'd1},  // R10
    {6'h1F, 6'h23, 6'h00, 2'd0},  // R6
    {6'h20, 6'h03, 6'h00, 2'd0},  // R5
    {6'h20, 6'h20, 6'h20, 2'd1}   // R10
  };

  initial begin
    logic [5:0] v;
    logic [5:0] v2;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1'b0, v); check("R1 enable", v, 0);
    rd(1'b1, v); check("R1 status", v, 0);
    check("R1 irq_pulse", irq_pulse, 0);
    check("R1 irq_level", irq_level, 0);
    rst_n = 1'b1;

    // R2 readback
    wr(1'b0, 6'h2A);
    rd(1'b0, v); check("R2 enable readback", v, 6'h2A);
    // R11 status write ignored
    wr(1'b1, 6'h3F);
    rd(1'b0, v); check("R11 enable after status write", v, 6'h2A);
    rd(1'b1, v); check("R11 status after status write", v, 0);
    wr(1'b0, 6'h00);

    for (int i = 0; i < 12; i++) begin
      int p0;
      wr(1'b0, VEC[i][19:14]);
      src_i = VEC[i][13:8];
      p0 = pulses;
      repeat (5) @(negedge clk);
      rd(1'b1, v);
      check($sformatf("R3/R4/R5/R6/R7 step %0d status", i), v, VEC[i][7:2]);
      check($sformatf("R8/R9/R10 step %0d pulses", i), pulses - p0, VEC[i][1:0]);
      check($sformatf("R8 step %0d level", i), irq_level, VEC[i][7:2] != 0);
    end

    // R2 reads have no side effect
    rd(1'b1, v); @(negedge clk); rd(1'b1, v2);
    check("R2 repeat read", v2, v);

    // R3 exact latency and R8 single-cycle pulse
    wr(1'b0, 6'h00);
    src_i = 6'h00;
    repeat (3) @(negedge clk);
    wr(1'b0, 6'h01);
    src_i = 6'h01;
    @(negedge clk); @(negedge clk);
    rd(1'b1, v); check("R3 before third edge", v, 0);
    @(negedge clk);
    rd(1'b1, v); check("R3 after third edge", v, 1);
    check("R8 pulse high", irq_pulse, 1);
    @(negedge clk);
    check("R8 pulse single cycle", irq_pulse, 0);
    check("R8 level held", irq_level, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule